// File: doc/BRIEF.md
# Clipped Cursor Overlay

This block lays a small ARGB pointer image over the outgoing video stream. The image lives in an internal 2048-word buffer. Software fills the buffer through a write port, and the block swaps the red and blue bytes of each word as it stores it. Position, size, screen dimensions and control bits go into shadow registers. The block copies them into its working geometry only when the timing generator signals the end of a frame, so the pointer never tears in the middle of a frame.

At commit time the block works out the clipped geometry:

- **Negative coordinates.** A cursor placed at a negative X or Y is pinned to the screen edge. The hidden strip is skipped by starting further into the bitmap.
- **Far edges.** A cursor running past the right or bottom edge is trimmed to what remains on screen.
- **Interlaced output.** The vertical position and height are halved, the bitmap row stride is doubled, and odd fields read the rows in between.

For each incoming pixel coordinate, the block either passes the background through or alpha-blends the cursor texel over it. The result leaves one clock later, together with the delayed coordinates.

Top module: `cursor_overlay`

## Requirements
- R1: After a synchronous active-low reset, `out_pix`, `out_x` and `out_y` read 0. The cursor stays invisible until the first frame-done commit of an enabled, legal setup, so every background pixel passes through unchanged.
- R2: A size is legal only if both of these hold:
  - width and height each lie in 1..64;
  - they do not both exceed 32.
  An illegal size leaves the cursor invisible.
- R3: A negative X (or Y) places the cursor at screen column (row) 0. The bitmap read starts `-X` pixels (`-Y` rows) in, and the visible width (height) shrinks by the same amount, never below 0.
- R4: When X+width exceeds the screen width, the visible width becomes screen width minus X, never below 0. The same rule applies vertically.
- R5: With the interlace bit set, the on-screen Y start and the visible height are halved (rounded down) and the row stride becomes twice the width. When `field_odd` is 1, the read address gains one extra width.
- R6: If the visible width or height works out to 0, the cursor is invisible.
- R7: Configuration writes select a register with `cfg_sel`:
  - 0: position, Y in bits 31:16 and X in bits 15:0, each 16-bit two's complement;
  - 1: size, height in bits 31:16 and width in bits 15:0;
  - 2: screen size, height in bits 31:16 and width in bits 15:0;
  - 3: control, bit 0 enable and bit 1 interlace.

  None of these writes alters the displayed cursor until a `frame_done` pulse.
- R8: A bitmap word written as {A, R, G, B} in bytes 31..0 is stored as {A, B, G, R}. The stored byte lanes 23:16, 15:8 and 7:0 line up with the same lanes of `bg_pix` and `out_pix`.
- R9: A size write whose value differs from the committed size hides the cursor from the next cycle until the next `frame_done`. Writing the committed size again has no effect.
- R10: A covered pixel becomes (a*c + (255-a)*b)/255 per lane, rounded down, where a is the stored alpha, c the stored lane and b the background lane. Alpha 0 returns the background.
- R11: `out_pix`, `out_x` and `out_y` belong to the pixel coordinates presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_sel | input | 2 | Shadow register select (0 pos, 1 size, 2 screen, 3 control) |
| cfg_wdata | input | 32 | Shadow register write data |
| frame_done | input | 1 | End-of-frame pulse that commits the shadow registers |
| bm_we | input | 1 | Bitmap write strobe |
| bm_addr | input | 11 | Bitmap word address |
| bm_wdata | input | 32 | Bitmap word, {A,R,G,B} |
| pix_x | input | 16 | Current pixel column |
| pix_y | input | 16 | Current line (field line when interlaced) |
| field_odd | input | 1 | Odd field flag |
| bg_pix | input | 24 | Background pixel |
| out_pix | output | 24 | Composited pixel |
| out_x | output | 16 | Delayed column |
| out_y | output | 16 | Delayed line |

## Verification
The bench targets these corner cases, each with the failure it would catch:

- **Negative-position clipping.** A design that forgets the bitmap offset shows the top-left of the image instead of the visible part.
- **Far-edge trimming.** A design that trims wrongly draws past the screen or underflows to a huge width.
- **Illegal and zero-visible sizes.** A design that ignores them draws a cursor that should stay hidden.
- **Interlaced fields.** A design that gets the halving or the odd-field row wrong shows stretched or shifted rows.
- **Deferred commits and the size-change blanking.** A design that applies writes early moves the cursor mid-frame. One that misses the blanking flashes a stale bitmap, and one that blanks on an identical size write loses the cursor for a frame.
- **Alpha extremes.** Opaque and fully transparent texels expose a byte-swap or blend error directly.

// File: rtl/cursor_pkg.sv
// Shared constants and types of the cursor overlay.
// Assumes a 16-bit coordinate space and a 2048-word bitmap buffer.
package cursor_pkg;
    localparam int CRD_W = 16;
    localparam int BM_AW = 11;

    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_SIZE = 2'd1,
        SEL_SCR  = 2'd2,
        SEL_CTRL = 2'd3
    } cfg_sel_e;

    // Committed, already clipped cursor geometry.
    typedef struct packed {
        logic             vis;
        logic             il;
        logic [CRD_W-1:0] xs;
        logic [CRD_W-1:0] ys;
        logic [CRD_W-1:0] wv;
        logic [CRD_W-1:0] hv;
        logic [BM_AW-1:0] base;
        logic [7:0]       stride;
        logic [7:0]       width;
    } geo_t;
endpackage

// File: rtl/cur_geom.sv
// Combinational clipper. It turns raw shadow values (position, size, screen,
// enable, interlace) into visible on-screen geometry and a bitmap start.
// Assumes position fields are 16-bit two's complement.
module cur_geom
    import cursor_pkg::*;
#(
    parameter int MAX_DIM  = 64,
    parameter int HALF_DIM = 32
) (
    input  logic [31:0] pos_i,
    input  logic [31:0] size_i,
    input  logic [31:0] scr_i,
    input  logic        en_i,
    input  logic        il_i,
    output geo_t        geo_o
);
    // Clip both axes, apply the interlace halving and set visibility.
    always_comb begin : p_clip
        int sx, sy, w, h, sw, sh;
        int xoff, yoff, xs, ys, wv, hv;
        logic ok;

        sx = int'($signed(pos_i[15:0]));
        sy = int'($signed(pos_i[31:16]));
        w  = int'(size_i[15:0]);
        h  = int'(size_i[31:16]);
        sw = int'(scr_i[15:0]);
        sh = int'(scr_i[31:16]);

        ok = (w >= 1) && (h >= 1) && (w <= MAX_DIM) && (h <= MAX_DIM)
             && !((w > HALF_DIM) && (h > HALF_DIM));

        if (sx < 0) begin
            xoff = -sx;
            xs   = 0;
            wv   = (w > xoff) ? w - xoff : 0;
        end else if (sx + w > sw) begin
            xoff = 0;
            xs   = sx;
            wv   = (sw > sx) ? sw - sx : 0;
        end else begin
            xoff = 0;
            xs   = sx;
            wv   = w;
        end

        if (sy < 0) begin
            yoff = -sy;
            ys   = 0;
            hv   = (h > yoff) ? h - yoff : 0;
        end else if (sy + h > sh) begin
            yoff = 0;
            ys   = sy;
            hv   = (sh > sy) ? sh - sy : 0;
        end else begin
            yoff = 0;
            ys   = sy;
            hv   = h;
        end

        if (il_i) begin
            ys = ys / 2;
            hv = hv / 2;
        end

        geo_o.vis    = en_i && ok && (wv > 0) && (hv > 0);
        geo_o.il     = il_i;
        geo_o.xs     = CRD_W'(xs);
        geo_o.ys     = CRD_W'(ys);
        geo_o.wv     = CRD_W'(wv);
        geo_o.hv     = CRD_W'(hv);
        geo_o.base   = BM_AW'(yoff * w + xoff);
        geo_o.stride = 8'(il_i ? 2 * w : w);
        geo_o.width  = 8'(w);
    end
endmodule

// File: rtl/cur_buf.sv
// Cursor bitmap store. Each write swaps the red and blue bytes so that lanes
// come out as {A,B,G,R}. The read is combinational.
// Assumes the caller keeps the read address inside the buffer.
module cur_buf #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [31:0]   wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [31:0]   rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    // Store the incoming word with its red and blue bytes exchanged.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= {wdata_i[31:24], wdata_i[7:0], wdata_i[15:8], wdata_i[23:16]};
        end
    end

    // Asynchronous texel read.
    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cur_blend.sv
// Alpha blender and output register. It mixes the texel over the background
// on a hit and registers the pixel with its coordinates (one-stage latency).
// Assumes the texel is {A, lane2, lane1, lane0}, lanes matching the background.
module cur_blend #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic [31:0]   tex_i,
    input  logic [23:0]   bg_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    output logic [23:0]   pix_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o
);
    logic [7:0]  alpha;
    logic [23:0] mix;

    assign alpha = tex_i[31:24];

    for (genvar k = 0; k < 3; k++) begin : g_lane
        logic [16:0] acc;
        // Weighted sum of texel and background for one colour lane.
        assign acc = {9'd0, alpha} * {9'd0, tex_i[8*k +: 8]}
                   + {9'd0, ~alpha} * {9'd0, bg_i[8*k +: 8]};
        assign mix[8*k +: 8] = 8'(acc / 17'd255);
    end

    // Output stage: pick the blended or background pixel, delay coordinates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o <= '0;
            x_o   <= '0;
            y_o   <= '0;
        end else begin
            pix_o <= hit_i ? mix : bg_i;
            x_o   <= x_i;
            y_o   <= y_i;
        end
    end

    a_r10_clear_texel: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && alpha == 8'd0) |=> pix_o == $past(bg_i));
    a_r10_opaque_texel: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && alpha == 8'hff) |=> pix_o == $past(tex_i[23:0]));
    a_r11_coord_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (x_o == $past(x_i) && y_o == $past(y_i)));
endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay. It holds the shadow registers, commits the
// clipped geometry on frame_done, blanks on a size change, forms the hit test
// and texel address, and feeds the blender.
// Assumes frame_done is a one-cycle pulse and that the bitmap is reloaded
// before the commit that follows a size change.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int MAX_DIM  = 64,
    parameter int HALF_DIM = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             frame_done,
    input  logic             bm_we,
    input  logic [BM_AW-1:0] bm_addr,
    input  logic [31:0]      bm_wdata,
    input  logic [CRD_W-1:0] pix_x,
    input  logic [CRD_W-1:0] pix_y,
    input  logic             field_odd,
    input  logic [23:0]      bg_pix,
    output logic [23:0]      out_pix,
    output logic [CRD_W-1:0] out_x,
    output logic [CRD_W-1:0] out_y
);
    localparam int AW    = BM_AW;
    localparam int DIM_W = $clog2(MAX_DIM) + 1;

    logic [31:0]      sh_pos, sh_size, sh_scr, act_size;
    logic             sh_en, sh_il;
    geo_t             geo_d, geo_q;
    logic             size_kill;
    logic [CRD_W-1:0] dx, dy;
    logic             hit;
    logic [AW-1:0]    raddr, fld_add;
    logic [31:0]      texel;

    // Shadow register writes from the configuration port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pos  <= '0;
            sh_size <= '0;
            sh_scr  <= '0;
            sh_en   <= 1'b0;
            sh_il   <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_POS:  sh_pos  <= cfg_wdata;
                SEL_SIZE: sh_size <= cfg_wdata;
                SEL_SCR:  sh_scr  <= cfg_wdata;
                SEL_CTRL: begin
                    sh_en <= cfg_wdata[0];
                    sh_il <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    cur_geom #(
        .MAX_DIM (MAX_DIM),
        .HALF_DIM(HALF_DIM)
    ) u_geom (
        .pos_i (sh_pos),
        .size_i(sh_size),
        .scr_i (sh_scr),
        .en_i  (sh_en),
        .il_i  (sh_il),
        .geo_o (geo_d)
    );

    assign size_kill = cfg_we && (cfg_sel == SEL_SIZE) && (cfg_wdata != act_size);

    // Commit on frame_done; otherwise blank at once on a differing size write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geo_q    <= '0;
            act_size <= '0;
        end else if (frame_done) begin
            geo_q    <= geo_d;
            act_size <= sh_size;
        end else if (size_kill) begin
            geo_q.vis <= 1'b0;
        end
    end

    // Hit test and texel address for the current coordinate.
    always_comb begin
        dx      = pix_x - geo_q.xs;
        dy      = pix_y - geo_q.ys;
        hit     = geo_q.vis && (pix_x >= geo_q.xs) && (dx < geo_q.wv)
                  && (pix_y >= geo_q.ys) && (dy < geo_q.hv);
        fld_add = (geo_q.il && field_odd) ? AW'(geo_q.width) : '0;
        raddr   = geo_q.base + AW'(dy[DIM_W-1:0]) * AW'(geo_q.stride)
                  + AW'(dx[DIM_W-1:0]) + fld_add;
    end

    cur_buf #(
        .AW(AW)
    ) u_buf (
        .clk    (clk),
        .we_i   (bm_we),
        .waddr_i(bm_addr),
        .wdata_i(bm_wdata),
        .raddr_i(raddr),
        .rdata_o(texel)
    );

    cur_blend #(
        .CW(CRD_W)
    ) u_blend (
        .clk  (clk),
        .rst_n(rst_n),
        .hit_i(hit),
        .tex_i(texel),
        .bg_i (bg_pix),
        .x_i  (pix_x),
        .y_i  (pix_y),
        .pix_o(out_pix),
        .x_o  (out_x),
        .y_o  (out_y)
    );

    a_r2_legal_shape: assert property (@(posedge clk) disable iff (!rst_n)
        geo_q.vis |-> (geo_q.wv <= MAX_DIM && geo_q.hv <= MAX_DIM
                       && !(geo_q.wv > HALF_DIM && geo_q.hv > HALF_DIM)));
    a_r6_nonzero_visible: assert property (@(posedge clk) disable iff (!rst_n)
        geo_q.vis |-> (geo_q.wv != '0 && geo_q.hv != '0));
    a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !size_kill) |=> $stable(geo_q));
    a_r6_hidden_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> out_pix == $past(bg_pix));
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
    localparam int SW = 80;
    localparam int SH = 48;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_done = 1'b0;
    logic        bm_we = 1'b0;
    logic [10:0] bm_addr = '0;
    logic [31:0] bm_wdata = '0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic        field_odd = 1'b0;
    logic [23:0] bg_pix = '0;
    logic [23:0] out_pix;
    logic [15:0] out_x, out_y;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] bmp [DEPTH];
    // shadow model
    logic [31:0] m_pos = '0, m_size = '0, m_scr = '0;
    bit m_en = 0, m_il = 0;
    // committed model
    bit a_vis = 0, a_il = 0;
    int a_xs, a_ys, a_wv, a_hv, a_base, a_stride, a_w;
    logic [31:0] a_size = '0;

    cursor_overlay uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frame_done(frame_done), .bm_we(bm_we),
        .bm_addr(bm_addr), .bm_wdata(bm_wdata), .pix_x(pix_x), .pix_y(pix_y),
        .field_odd(field_odd), .bg_pix(bg_pix), .out_pix(out_pix),
        .out_x(out_x), .out_y(out_y)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, got cycle %0d expected < 190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] mixl(logic [7:0] a, logic [7:0] c, logic [7:0] b);
        int v;
        v = (int'(a) * int'(c) + (255 - int'(a)) * int'(b)) / 255;
        return 8'(v);
    endfunction

    function automatic logic [23:0] ref_pix(int x, int y, bit fld, logic [23:0] bg);
        int idx;
        logic [31:0] raw;
        if (!(a_vis && x >= a_xs && x < a_xs + a_wv && y >= a_ys && y < a_ys + a_hv))
            return bg;
        idx = a_base + (y - a_ys) * a_stride + (x - a_xs) + ((a_il && fld) ? a_w : 0);
        raw = bmp[idx % DEPTH];
        return {mixl(raw[31:24], raw[7:0], bg[23:16]),
                mixl(raw[31:24], raw[15:8], bg[15:8]),
                mixl(raw[31:24], raw[23:16], bg[7:0])};
    endfunction

    function automatic logic [31:0] pk(int hi, int lo);
        return {16'(hi), 16'(lo)};
    endfunction

    task automatic cfg_write(int sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        case (sel)
            0: m_pos = d;
            1: begin
                m_size = d;
                if (d != a_size) a_vis = 0;   // R9 blanking on size change
            end
            2: m_scr = d;
            default: begin m_en = d[0]; m_il = d[1]; end
        endcase
    endtask

    task automatic commit();
        int sx, sy, w, h, sw, sh, xoff, yoff;
        bit ok;
        @(negedge clk);
        frame_done = 1;
        @(negedge clk);
        frame_done = 0;
        sx = int'($signed(m_pos[15:0])); sy = int'($signed(m_pos[31:16]));
        w = int'(m_size[15:0]); h = int'(m_size[31:16]);
        sw = int'(m_scr[15:0]); sh = int'(m_scr[31:16]);
        ok = w >= 1 && h >= 1 && w <= 64 && h <= 64 && !(w > 32 && h > 32);
        xoff = 0; yoff = 0; a_xs = sx; a_ys = sy; a_wv = w; a_hv = h;
        if (sx < 0) begin xoff = -sx; a_xs = 0; a_wv = (w > xoff) ? w - xoff : 0; end
        else if (sx + w > sw) a_wv = (sw > sx) ? sw - sx : 0;
        if (sy < 0) begin yoff = -sy; a_ys = 0; a_hv = (h > yoff) ? h - yoff : 0; end
        else if (sy + h > sh) a_hv = (sh > sy) ? sh - sy : 0;
        if (m_il) begin a_ys = a_ys / 2; a_hv = a_hv / 2; end
        a_stride = m_il ? 2 * w : w;
        a_w = w; a_il = m_il;
        a_base = yoff * w + xoff;
        a_vis = m_en && ok && a_wv > 0 && a_hv > 0;
        a_size = m_size;
    endtask

    task automatic scan(bit fld, string tag);
        logic [23:0] exp_p;
        int px, py;
        bit have = 0;
        for (int y = 0; y < SH; y++) begin
            for (int x = 0; x < SW; x++) begin
                @(negedge clk);
                if (have) begin
                    checks++;
                    if (out_pix !== exp_p) begin
                        fails++;
                        $display("FAIL %s pixel (%0d,%0d) got %h expected %h", tag, px, py, out_pix, exp_p);
                    end
                    checks++;
                    if (out_x !== 16'(px) || out_y !== 16'(py)) begin
                        fails++;
                        $display("FAIL R11 coords got (%0d,%0d) expected (%0d,%0d)", out_x, out_y, px, py);
                    end
                end
                field_odd = fld; pix_x = 16'(x); pix_y = 16'(y); bg_pix = 24'($urandom);
                exp_p = ref_pix(x, y, fld, bg_pix);
                px = x; py = y; have = 1;
            end
        end
        @(negedge clk);
        checks++;
        if (out_pix !== exp_p) begin
            fails++;
            $display("FAIL %s pixel (%0d,%0d) got %h expected %h", tag, px, py, out_pix, exp_p);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (out_pix !== 24'd0 || out_x !== 16'd0 || out_y !== 16'd0) begin
            fails++;
            $display("FAIL R1 reset outputs got %h/%0d/%0d expected 0/0/0", out_pix, out_x, out_y);
        end

        // Bitmap: random words, with alpha forced to 0 or 255 on a share (R8, R10)
        for (int i = 0; i < DEPTH; i++) begin
            logic [31:0] d;
            d = $urandom;
            if (i % 5 == 0) d[31:24] = 8'h00;
            if (i % 5 == 1) d[31:24] = 8'hff;
            bmp[i] = d;
            @(negedge clk);
            bm_we = 1; bm_addr = 11'(i); bm_wdata = d;
        end
        @(negedge clk);
        bm_we = 0;

        cfg_write(2, pk(SH, SW));
        scan(0, "R1");                           // nothing committed yet

        cfg_write(1, pk(64, 32));
        cfg_write(0, pk(5, 10));
        cfg_write(3, 32'h1);
        commit();
        scan(0, "R4 R8 R10");                    // 32x64, bottom clipped

        cfg_write(1, pk(32, 64));
        scan(0, "R9");                           // size differs: blanked
        cfg_write(0, pk(-3, -5));
        commit();
        scan(0, "R3");                           // negative clip

        cfg_write(1, pk(16, 16));
        cfg_write(0, pk(40, 70));
        commit();
        scan(0, "R4");                           // right and bottom clip

        cfg_write(0, pk(10, 90));
        commit();
        scan(0, "R6");                           // fully off right edge
        cfg_write(0, pk(60, 10));
        commit();
        scan(0, "R6");                           // fully below

        cfg_write(1, pk(48, 48));
        cfg_write(0, pk(4, 4));
        commit();
        scan(0, "R2");                           // both dims above 32
        cfg_write(1, pk(1, 65));
        commit();
        scan(0, "R2");                           // too wide

        cfg_write(1, pk(16, 16));
        cfg_write(0, pk(20, 20));
        commit();
        cfg_write(0, pk(30, 40));
        scan(0, "R7");                           // old position still shown
        commit();
        scan(0, "R7");
        cfg_write(1, pk(16, 16));
        scan(0, "R9");                           // same size: stays visible

        cfg_write(1, pk(30, 20));
        cfg_write(0, pk(-4, 30));
        cfg_write(3, 32'h3);
        commit();
        scan(0, "R5");
        scan(1, "R5");

        for (int n = 0; n < 7; n++) begin
            int w, h, x, y;
            bit il;
            w = 1 + int'($urandom % 64); h = 1 + int'($urandom % 64);
            x = int'($urandom % 120) - 30; y = int'($urandom % 80) - 30;
            il = 1'($urandom % 2);
            cfg_write(1, pk(h, w));
            cfg_write(0, pk(y, x));
            cfg_write(3, {30'd0, il, 1'b1});
            commit();
            scan(0, "R10");
            if (il) scan(1, "R5");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule